// File: doc/BRIEF.md
# Stack Frame Unit with Page-Boundary Fault

This unit carries out the stack side of a 16-bit word-addressed processor: single-word push and pop of an accumulator, the subroutine-entry save that stores a five-word return frame, and the matching return that unwinds it. It holds the stack pointer and the frame pointer. It reaches memory through a single-port word interface in which a request is held until the memory answers ready. The processor core hands over the instruction word, its own address, the four accumulators, the carry and the interrupt-enable state with a one-cycle start strobe. It takes back the updated accumulators and carry, and a jump target when one is due, on a one-cycle done strobe.

Each pointer step is checked against a 256-word page. A step that would leave the page while interrupts are enabled is not performed. The unit instead records the instruction address in memory word 0 and fetches a jump target from memory word 3. With interrupts disabled the pointer wraps into the next page without complaint.

Top module: `stack_frame_unit`

## Requirements
- R1: An instruction word is recognised only when bits [15:13] are 3'b011 and bits [5:0] are 6'd1. The accumulator selector is bits [12:11], the operation field is bits [10:8] and the modifier is bits [7:6]. The operations are: push {010,00}, pop {001,00}, save {101,00}, return {101,10}, load stack pointer {110,00}, load frame pointer {110,01}.
- R2: Push increments the stack pointer, then writes the selected accumulator to the new stack pointer address.
- R3: Pop reads the word at the stack pointer into the selected accumulator, then decrements the stack pointer.
- R4: Save pushes five words in this order: AC0, AC1, AC2, the frame pointer, then {carry, AC3[14:0]}. It then copies the final stack pointer into both the frame pointer and AC3.
- R5: Return sets the stack pointer to the frame pointer and pops five words. The first popped word supplies the carry from bit 15 and the jump target from bits [14:0]. The next four words restore AC3, AC2, AC1 and AC0. The restored AC3 is then copied into the frame pointer and jump_o is raised. The stack pointer ends at the old frame pointer minus 5.
- R6: Load stack pointer and load frame pointer copy the selected accumulator into the named pointer without any memory access.
- R7: When a step would change stack pointer bits [15:8] and interrupts were enabled at start, that step and its access are skipped, and the stack pointer keeps its pre-step value. Words moved by earlier steps stay in place. The unit writes {0, instruction address} to word 0, reads word 3, and signals fault_o and jump_o with the target taken from bits [14:0] of word 3.
- R8: With interrupts disabled, a step that crosses a page proceeds normally and no fault is raised.
- R9: A memory request keeps its address, direction and write data until ready is seen, and only one access is outstanding at a time.
- R10: An unrecognised instruction word causes no memory request and leaves both pointers, the accumulators and the carry unchanged. Done still follows.
- R11: After reset the stack pointer equals SP_RST, the frame pointer equals FP_RST, the unit is idle and no memory request is raised.
- R12: busy_o is high from acceptance until the cycle of done_o. done_o lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken while idle |
| instr_i | input | 16 | Instruction word |
| pc_i | input | 15 | Address of the instruction |
| int_en_i | input | 1 | Interrupts enabled |
| ac0_i | input | 16 | Accumulator 0 in |
| ac1_i | input | 16 | Accumulator 1 in |
| ac2_i | input | 16 | Accumulator 2 in |
| ac3_i | input | 16 | Accumulator 3 in |
| carry_i | input | 1 | Carry in |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished, results valid |
| ac0_o | output | 16 | Accumulator 0 result |
| ac1_o | output | 16 | Accumulator 1 result |
| ac2_o | output | 16 | Accumulator 2 result |
| ac3_o | output | 16 | Accumulator 3 result |
| carry_o | output | 1 | Carry result |
| sp_o | output | 16 | Stack pointer |
| fp_o | output | 16 | Frame pointer |
| jump_o | output | 1 | Jump target valid |
| jump_pc_o | output | 15 | Jump target |
| fault_o | output | 1 | Page fault taken |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data |
| mem_ready_i | input | 1 | Memory ready |

## Verification
The bench loads the stack pointer just below and just above a page edge and then issues saves, returns, pushes and pops. These hit a crossing in the middle of a frame. A design that tested the crossing after the access would leave one extra word written, or the pointer one step too far. A design that ignored the enable would trap with interrupts off. A return that loaded the frame pointer from the wrong popped word, or swapped carry and target, would break the save/return round trip. Random memory latency exposes a request that drops or moves its address before ready. Malformed words with a wrong device code or an unused operation show whether a design touches memory or the pointers when it should not.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
    typedef enum logic [2:0] {
        OP_NONE, OP_PUSH, OP_POP, OP_SAV, OP_RET, OP_LDSP, OP_LDFP
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_STEP, ST_MEM, ST_FLTW, ST_FLTR, ST_DONE
    } st_e;

    localparam logic [2:0] MAJOR_IO  = 3'b011;
    localparam logic [5:0] DEV_STACK = 6'd1;
    localparam logic [2:0] XF_PUSH   = 3'b010;
    localparam logic [2:0] XF_POP    = 3'b001;
    localparam logic [2:0] XF_FRAME  = 3'b101;
    localparam logic [2:0] XF_LOAD   = 3'b110;
    localparam int unsigned FRAME_WORDS = 5;
endpackage

// File: rtl/sfu_decode.sv
module sfu_decode
    import sfu_pkg::*;
(
    input  logic [15:0] instr_i,
    output op_e         op_o,
    output logic [1:0]  sel_o
);
    logic [2:0] xf;
    logic [1:0] md;
    logic       hit;

    assign xf    = instr_i[10:8];
    assign md    = instr_i[7:6];
    assign sel_o = instr_i[12:11];
    assign hit   = (instr_i[15:13] == MAJOR_IO) && (instr_i[5:0] == DEV_STACK);

    always_comb begin
        op_o = OP_NONE;
        if (hit) begin
            unique case ({xf, md})
                {XF_PUSH,  2'b00}: op_o = OP_PUSH;
                {XF_POP,   2'b00}: op_o = OP_POP;
                {XF_FRAME, 2'b00}: op_o = OP_SAV;
                {XF_FRAME, 2'b10}: op_o = OP_RET;
                {XF_LOAD,  2'b00}: op_o = OP_LDSP;
                {XF_LOAD,  2'b01}: op_o = OP_LDFP;
                default:           op_o = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sfu_page_guard.sv
module sfu_page_guard #(
    parameter int W  = 16,
    parameter int PB = 8
) (
    input  logic [W-1:0] cur_i,
    input  logic         down_i,
    output logic [W-1:0] nxt_o,
    output logic         cross_o
);
    assign nxt_o = down_i ? cur_i - W'(1) : cur_i + W'(1);

    generate
        if (PB < W) begin : g_paged
            assign cross_o = (nxt_o[W-1:PB] != cur_i[W-1:PB]);
        end else begin : g_flat
            assign cross_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/stack_frame_unit.sv
module stack_frame_unit
    import sfu_pkg::*;
#(
    parameter int          W         = 16,
    parameter int          PAGE_BITS = 8,
    parameter logic [15:0] SP_RST    = 16'h0040,
    parameter logic [15:0] FP_RST    = 16'h0040,
    parameter logic [15:0] SAVE_LOC  = 16'd0,
    parameter logic [15:0] VEC_LOC   = 16'd3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [W-1:0]  instr_i,
    input  logic [W-2:0]  pc_i,
    input  logic          int_en_i,
    input  logic [W-1:0]  ac0_i,
    input  logic [W-1:0]  ac1_i,
    input  logic [W-1:0]  ac2_i,
    input  logic [W-1:0]  ac3_i,
    input  logic          carry_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [W-1:0]  ac0_o,
    output logic [W-1:0]  ac1_o,
    output logic [W-1:0]  ac2_o,
    output logic [W-1:0]  ac3_o,
    output logic          carry_o,
    output logic [W-1:0]  sp_o,
    output logic [W-1:0]  fp_o,
    output logic          jump_o,
    output logic [W-2:0]  jump_pc_o,
    output logic          fault_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [W-1:0]  mem_addr_o,
    output logic [W-1:0]  mem_wdata_o,
    input  logic [W-1:0]  mem_rdata_i,
    input  logic          mem_ready_i
);
    localparam logic [2:0] LAST_IDX = 3'(FRAME_WORDS - 1);

    typedef struct packed {
        st_e                 st;
        op_e                 op;
        logic [1:0]          sel;
        logic [2:0]          idx;
        logic                ie;
        logic [W-2:0]        pc;
        logic [W-1:0]        sp;
        logic [W-1:0]        fp;
        logic [3:0][W-1:0]   ac;
        logic                cy;
        logic                req;
        logic                we;
        logic [W-1:0]        addr;
        logic [W-1:0]        wdata;
        logic                jump;
        logic                fault;
        logic [W-2:0]        jpc;
    } sfu_state_t;

    sfu_state_t q, d;

    op_e               dec_op;
    logic [1:0]        dec_sel;
    logic [3:0][W-1:0] ac_in;
    logic              step_down;
    logic [W-1:0]      step_nxt;
    logic              step_cross;
    logic              is_last;
    logic [W-1:0]      push_word;

    assign ac_in = {ac3_i, ac2_i, ac1_i, ac0_i};

    sfu_decode u_dec (
        .instr_i (instr_i),
        .op_o    (dec_op),
        .sel_o   (dec_sel)
    );

    assign step_down = (q.op == OP_POP) || (q.op == OP_RET);

    sfu_page_guard #(.W(W), .PB(PAGE_BITS)) u_guard (
        .cur_i   (q.sp),
        .down_i  (step_down),
        .nxt_o   (step_nxt),
        .cross_o (step_cross)
    );

    assign is_last = ((q.op == OP_SAV) || (q.op == OP_RET)) ? (q.idx == LAST_IDX) : 1'b1;

    always_comb begin
        push_word = q.ac[q.sel];
        if (q.op == OP_SAV) begin
            unique case (q.idx)
                3'd0, 3'd1, 3'd2: push_word = q.ac[q.idx[1:0]];
                3'd3:             push_word = q.fp;
                default:          push_word = {q.cy, q.ac[3][W-2:0]};
            endcase
        end
    end

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.op    = dec_op;
                    d.sel   = dec_sel;
                    d.ac    = ac_in;
                    d.cy    = carry_i;
                    d.pc    = pc_i;
                    d.ie    = int_en_i;
                    d.idx   = '0;
                    d.jump  = 1'b0;
                    d.fault = 1'b0;
                    unique case (dec_op)
                        OP_PUSH, OP_POP, OP_SAV: d.st = ST_STEP;
                        OP_RET: begin
                            d.sp = q.fp;
                            d.st = ST_STEP;
                        end
                        OP_LDSP: begin
                            d.sp = ac_in[dec_sel];
                            d.st = ST_DONE;
                        end
                        OP_LDFP: begin
                            d.fp = ac_in[dec_sel];
                            d.st = ST_DONE;
                        end
                        default: d.st = ST_DONE;
                    endcase
                end
            end
            ST_STEP: begin
                d.req = 1'b1;
                if (step_cross && q.ie) begin
                    d.we    = 1'b1;
                    d.addr  = SAVE_LOC;
                    d.wdata = {1'b0, q.pc};
                    d.st    = ST_FLTW;
                end else begin
                    d.sp = step_nxt;
                    d.st = ST_MEM;
                    if (step_down) begin
                        d.we   = 1'b0;
                        d.addr = q.sp;
                    end else begin
                        d.we    = 1'b1;
                        d.addr  = step_nxt;
                        d.wdata = push_word;
                    end
                end
            end
            ST_MEM: begin
                if (mem_ready_i) begin
                    d.req = 1'b0;
                    if (q.op == OP_POP) begin
                        d.ac[q.sel] = mem_rdata_i;
                    end else if (q.op == OP_RET) begin
                        if (q.idx == 3'd0) begin
                            d.cy  = mem_rdata_i[W-1];
                            d.jpc = mem_rdata_i[W-2:0];
                        end else begin
                            d.ac[2'(3'd4 - q.idx)] = mem_rdata_i;
                        end
                    end
                    if (is_last) begin
                        d.st = ST_DONE;
                        if (q.op == OP_SAV) begin
                            d.fp    = q.sp;
                            d.ac[3] = q.sp;
                        end else if (q.op == OP_RET) begin
                            d.fp   = q.ac[3];
                            d.jump = 1'b1;
                        end
                    end else begin
                        d.idx = q.idx + 3'd1;
                        d.st  = ST_STEP;
                    end
                end
            end
            ST_FLTW: begin
                if (mem_ready_i) begin
                    d.we   = 1'b0;
                    d.addr = VEC_LOC;
                    d.st   = ST_FLTR;
                end
            end
            ST_FLTR: begin
                if (mem_ready_i) begin
                    d.req   = 1'b0;
                    d.jpc   = mem_rdata_i[W-2:0];
                    d.jump  = 1'b1;
                    d.fault = 1'b1;
                    d.st    = ST_DONE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q    <= '0;
            q.sp <= SP_RST;
            q.fp <= FP_RST;
        end else begin
            q <= d;
        end
    end

    assign busy_o      = (q.st != ST_IDLE);
    assign done_o      = (q.st == ST_DONE);
    assign ac0_o       = q.ac[0];
    assign ac1_o       = q.ac[1];
    assign ac2_o       = q.ac[2];
    assign ac3_o       = q.ac[3];
    assign carry_o     = q.cy;
    assign sp_o        = q.sp;
    assign fp_o        = q.fp;
    assign jump_o      = q.jump;
    assign jump_pc_o   = q.jpc;
    assign fault_o     = q.fault;
    assign mem_req_o   = q.req;
    assign mem_we_o    = q.we;
    assign mem_addr_o  = q.addr;
    assign mem_wdata_o = q.wdata;
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker
    import sfu_pkg::*;
#(
    parameter int W  = 16,
    parameter int PB = 8
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         busy_o,
    input logic         done_o,
    input logic         fault_o,
    input logic         jump_o,
    input logic [W-1:0] sp_o,
    input logic         mem_req_o,
    input logic         mem_we_o,
    input logic [W-1:0] mem_addr_o,
    input logic         mem_ready_i,
    input logic         ie,
    input op_e          op
);
    p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_ready_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    p_idle_no_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !mem_req_o);

    p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_fault_jump_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault_o && busy_o) |-> (jump_o && done_o));

    p_page_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && ie && (op == OP_PUSH || op == OP_POP || op == OP_SAV)) |=>
            (sp_o[W-1:PB] == $past(sp_o[W-1:PB])));

    p_no_fault_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !ie) |-> !fault_o);
endmodule

bind stack_frame_unit sfu_checker #(.W(W), .PB(PAGE_BITS)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .jump_o      (jump_o),
    .sp_o        (sp_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ready_i (mem_ready_i),
    .ie          (q.ie),
    .op          (q.op)
);

// File: tb/stack_frame_unit_tb.sv
module stack_frame_unit_tb;
    localparam logic [15:0] SPR = 16'h0040;
    localparam logic [15:0] FPR = 16'h0040;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        start_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic [14:0] pc_i = '0;
    logic        int_en_i = 1'b0;
    logic [15:0] ac0_i = '0, ac1_i = '0, ac2_i = '0, ac3_i = '0;
    logic        carry_i = 1'b0;
    logic        busy_o, done_o, carry_o, jump_o, fault_o;
    logic [15:0] ac0_o, ac1_o, ac2_o, ac3_o, sp_o, fp_o;
    logic [14:0] jump_pc_o;
    logic        mem_req_o, mem_we_o;
    logic [15:0] mem_addr_o, mem_wdata_o;
    logic [15:0] mem_rdata_i = '0;
    logic        mem_ready_i = 1'b0;

    stack_frame_unit #(.SP_RST(SPR), .FP_RST(FPR)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .instr_i(instr_i),
        .pc_i(pc_i), .int_en_i(int_en_i), .ac0_i(ac0_i), .ac1_i(ac1_i),
        .ac2_i(ac2_i), .ac3_i(ac3_i), .carry_i(carry_i), .busy_o(busy_o),
        .done_o(done_o), .ac0_o(ac0_o), .ac1_o(ac1_o), .ac2_o(ac2_o),
        .ac3_o(ac3_o), .carry_o(carry_o), .sp_o(sp_o), .fp_o(fp_o),
        .jump_o(jump_o), .jump_pc_o(jump_pc_o), .fault_o(fault_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .mem_ready_i(mem_ready_i)
    );

    logic [15:0] mem [65536];
    logic [15:0] mm  [65536];
    int          n_cmp = 0;
    int          n_bad = 0;
    int          wait_cnt = 0;
    bit          req_seen = 0;
    int          hs_err = 0;
    logic [15:0] last_addr = '0;
    bit          last_pending = 0;

    // memory model: answers a held request after 0..2 idle negedges
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready_i = 1'b0;
            last_pending = 0;
        end else if (mem_ready_i) begin
            mem_ready_i = 1'b0;
            last_pending = 0;
        end else if (mem_req_o) begin
            req_seen = 1;
            if (last_pending && mem_addr_o != last_addr) hs_err++;
            last_pending = 1;
            last_addr = mem_addr_o;
            if (wait_cnt == 0) begin
                mem_ready_i = 1'b1;
                if (mem_we_o) mem[mem_addr_o] = mem_wdata_o;
                else mem_rdata_i = mem[mem_addr_o];
                wait_cnt = int'($urandom % 3);
            end else begin
                wait_cnt--;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // reference model state
    logic [15:0] m_sp, m_fp, m_ac[4];
    logic        m_cy, m_jump, m_fault;
    logic [14:0] m_jpc;
    logic [15:0] acin[4];
    logic        cyin;

    function automatic logic [15:0] mk(input logic [2:0] xf, input logic [1:0] md, input logic [1:0] s);
        return {3'b011, s, xf, md, 6'd1};
    endfunction

    task automatic m_step(input bit down, input bit ie, input logic [15:0] w,
                          output logic [15:0] r, output bit f);
        logic [15:0] n;
        n = down ? m_sp - 16'd1 : m_sp + 16'd1;
        r = '0;
        f = 0;
        if (ie && n[15:8] != m_sp[15:8]) f = 1;
        else if (down) begin r = mm[m_sp]; m_sp = n; end
        else begin m_sp = n; mm[m_sp] = w; end
    endtask

    task automatic model(input logic [15:0] ins, input logic [14:0] pc, input bit ie, output string tag);
        logic [2:0] xf; logic [1:0] md, s; logic [15:0] r, w; logic [14:0] tpc;
        bit f, ok;
        xf = ins[10:8]; md = ins[7:6]; s = ins[12:11];
        ok = (ins[15:13] == 3'b011) && (ins[5:0] == 6'd1);
        for (int i = 0; i < 4; i++) m_ac[i] = acin[i];
        m_cy = cyin; m_jump = 0; m_fault = 0; f = 0; tpc = '0;
        tag = "R10";
        if (ok && xf == 3'b010 && md == 2'b00) begin
            tag = "R2"; m_step(0, ie, m_ac[s], r, f);
        end else if (ok && xf == 3'b001 && md == 2'b00) begin
            tag = "R3"; m_step(1, ie, '0, r, f);
            if (!f) m_ac[s] = r;
        end else if (ok && xf == 3'b101 && md == 2'b00) begin
            tag = "R4";
            for (int k = 0; k < 5 && !f; k++) begin
                w = (k < 3) ? m_ac[k] : (k == 3) ? m_fp : {m_cy, m_ac[3][14:0]};
                m_step(0, ie, w, r, f);
            end
            if (!f) begin m_fp = m_sp; m_ac[3] = m_sp; end
        end else if (ok && xf == 3'b101 && md == 2'b10) begin
            tag = "R5"; m_sp = m_fp;
            for (int k = 0; k < 5 && !f; k++) begin
                m_step(1, ie, '0, r, f);
                if (!f) begin
                    if (k == 0) begin m_cy = r[15]; tpc = r[14:0]; end
                    else m_ac[4-k] = r;
                end
            end
            if (!f) begin m_fp = m_ac[3]; m_jump = 1; m_jpc = tpc; end
        end else if (ok && xf == 3'b110 && md == 2'b00) begin
            tag = "R6"; m_sp = m_ac[s];
        end else if (ok && xf == 3'b110 && md == 2'b01) begin
            tag = "R6"; m_fp = m_ac[s];
        end
        if (f) begin
            tag = "R7";
            mm[0] = {1'b0, pc};
            m_jpc = mm[3][14:0];
            m_jump = 1; m_fault = 1;
        end else if (ie == 0 && tag != "R10" && tag != "R6") begin
            tag = {tag, "/R8"};
        end
    endtask

    task automatic do_op(input logic [15:0] ins, input logic [14:0] pc, input bit ie);
        string tag; int n;
        model(ins, pc, ie, tag);
        @(negedge clk);
        instr_i = ins; pc_i = pc; int_en_i = ie;
        ac0_i = acin[0]; ac1_i = acin[1]; ac2_i = acin[2]; ac3_i = acin[3];
        carry_i = cyin; start_i = 1'b1; req_seen = 0;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!done_o && n < 300) begin @(negedge clk); n++; end
        if (!done_o) begin
            n_cmp++; n_bad++;
            $display("FAIL R12 watchdog: got no done expected done");
            return;
        end
        chk({tag, " sp"}, 32'(sp_o), 32'(m_sp));
        chk({tag, " fp"}, 32'(fp_o), 32'(m_fp));
        chk({tag, " ac0"}, 32'(ac0_o), 32'(m_ac[0]));
        chk({tag, " ac1"}, 32'(ac1_o), 32'(m_ac[1]));
        chk({tag, " ac2"}, 32'(ac2_o), 32'(m_ac[2]));
        chk({tag, " ac3"}, 32'(ac3_o), 32'(m_ac[3]));
        chk({tag, " carry"}, 32'(carry_o), 32'(m_cy));
        chk({tag, " fault"}, 32'(fault_o), 32'(m_fault));
        chk({tag, " jump"}, 32'(jump_o), 32'(m_jump));
        if (m_jump) chk({tag, " target"}, 32'(jump_pc_o), 32'(m_jpc));
        if (m_fault) chk("R7 saved pc", 32'(mem[0]), 32'({1'b0, pc}));
        if (tag == "R10") chk("R10 no request", 32'(req_seen), 32'd0);
        @(negedge clk);
        chk("R12 done pulse", 32'({done_o, busy_o}), 32'd0);
        for (int i = 0; i < 4; i++) acin[i] = m_ac[i];
        cyin = m_cy;
    endtask

    int unsigned sd;
    initial begin
        sd = $urandom(32'h5EED);
        for (int i = 0; i < 65536; i++) begin
            mem[i] = 16'(i * 40503 + 7);
            mm[i]  = mem[i];
        end
        m_sp = SPR; m_fp = FPR;
        for (int i = 0; i < 4; i++) acin[i] = 16'(16'h1111 * (i + 1));
        cyin = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 busy/req/done", 32'({busy_o, mem_req_o, done_o}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 sp", 32'(sp_o), 32'(SPR));
        chk("R11 fp", 32'(fp_o), 32'(FPR));
        chk("R11 idle", 32'({busy_o, mem_req_o}), 32'd0);

        // directed: R1 encodings, R7 mid-frame fault, R8 wrap, R5 round trip
        acin[0] = 16'h01FD;
        do_op(mk(3'b110, 2'b00, 2'd0), 15'h0100, 1);
        acin[1] = 16'h0123;
        do_op(mk(3'b110, 2'b01, 2'd1), 15'h0101, 1);
        do_op(mk(3'b101, 2'b00, 2'd0), 15'h0102, 1);
        acin[0] = 16'h01FD;
        do_op(mk(3'b110, 2'b00, 2'd0), 15'h0103, 1);
        do_op(mk(3'b101, 2'b00, 2'd0), 15'h0104, 0);
        acin[0] = 16'hAAAA; acin[1] = 16'hBBBB; acin[2] = 16'hCCCC;
        do_op(mk(3'b101, 2'b10, 2'd0), 15'h0105, 1);
        acin[2] = 16'h0300;
        do_op(mk(3'b110, 2'b00, 2'd2), 15'h0106, 1);
        do_op(mk(3'b001, 2'b00, 2'd3), 15'h0107, 1);
        do_op(mk(3'b001, 2'b00, 2'd3), 15'h0108, 0);
        do_op(mk(3'b010, 2'b00, 2'd1), 15'h0109, 1);
        do_op(16'h6302, 15'h010A, 1);
        do_op(mk(3'b111, 2'b00, 2'd0), 15'h010B, 1);
        do_op(mk(3'b101, 2'b01, 2'd0), 15'h010C, 1);

        // constrained random mix
        for (int it = 0; it < 500; it++) begin
            int unsigned pick;
            logic [1:0] s;
            logic [15:0] ins;
            pick = $urandom % 16;
            s = 2'($urandom % 4);
            if ($urandom % 4 == 0) acin[$urandom % 4] = 16'($urandom);
            cyin = ($urandom % 2 == 1) ? cyin : ~cyin;
            if (pick < 4)       ins = mk(3'b010, 2'b00, s);
            else if (pick < 7)  ins = mk(3'b001, 2'b00, s);
            else if (pick < 10) ins = mk(3'b101, 2'b00, s);
            else if (pick < 12) ins = mk(3'b101, 2'b10, s);
            else if (pick < 14) begin
                acin[s] = {8'($urandom), 8'(8'hF9 + $urandom % 14)};
                ins = mk(3'b110, 2'(pick - 12), s);
            end else if (pick == 14) ins = {3'b011, s, 3'b101, 2'b00, 6'($urandom % 63 + 2)};
            else ins = 16'($urandom);
            do_op(ins, 15'($urandom), ($urandom % 4) != 0);
        end
        chk("R9 request held until ready", 32'(hs_err), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R12 global watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule